// File: doc/BRIEF.md
# HDLC Receive Deframer with Abort Rollback

This block turns an already recovered serial bit stream into framed bytes. Each input bit is qualified by a one-cycle valid strobe. The receiver waits in hunt mode until it sees the flag pattern. It then removes the zero bits that the transmitter inserted after runs of ones and packs the remaining bits into bytes, least significant bit first. The bytes it delivers to a valid/ready byte sink each carry an end-of-frame tag and an abort marker.

Completed bytes do not go to the sink straight away. They wait in a small hold queue that always keeps back the two newest bytes of the open frame. A run of seven ones may have already completed a byte out of abort bits. Because that byte is still held, the receiver can roll it back. On an abort it drops the partial byte and the newest held byte, and it hands the older held byte to the sink tagged as the end of an aborted frame. It also pulses an interrupt and returns to hunt mode. Frames are assumed to carry a whole number of bytes. The sink is expected to keep up; a byte that finds the queue full is discarded.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While and right after reset, `out_valid` and `abort_irq` are low.
- R2: In hunt mode (after reset, after an abort, or after the receiver is re-enabled), every bit is ignored until the flag 0x7E (a zero, six ones, a zero) has been received.
- R3: Inside a frame, a zero that follows five consecutive ones is dropped. The remaining bits form bytes least significant bit first. A bit counts only in a cycle where `bit_valid` is high.
- R4: A closing flag releases every held byte of the frame in arrival order. The last byte has `out_eof`=1 and `out_abort`=0, and all earlier bytes have `out_eof`=0.
- R5: Consecutive flags with no data between them deliver no byte.
- R6: Seven consecutive ones inside a frame are an abort. The partial bits and the newest held byte are discarded. If two bytes were held, the older one is delivered with `out_eof`=1 and `out_abort`=1. If fewer were held, nothing is delivered.
- R7: Each abort raises `abort_irq` for exactly one clock cycle.
- R8: Driving `rx_en` low clears the partial byte and every queued byte (so `out_valid` is low on the next cycle) and puts the receiver in hunt mode.
- R9: While `out_valid` is high and `out_ready` is low, the output byte and its tags hold steady. Bytes leave in the order they were received.
- R10: `out_abort` is only ever high together with `out_eof`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low clears the receiver and holds it cleared |
| bit_valid | input | 1 | Qualifies `bit_in` for one cycle |
| bit_in | input | 1 | Recovered serial bit |
| out_ready | input | 1 | Sink accepts the byte on offer |
| out_valid | output | 1 | A byte is on offer |
| out_data | output | 8 | Received byte |
| out_eof | output | 1 | Last byte of a frame |
| out_abort | output | 1 | Frame ended by an abort |
| abort_irq | output | 1 | One-cycle pulse per abort |

## Verification
A wrong ones-run count shows up at the ports in one of three ways. A stuffed zero is kept or a real bit is lost, so every later byte of the frame arrives shifted. A flag is never seen, so nothing is delivered. A false abort fires `abort_irq`. Each of these appears within two cycles of the offending bit. A fault in the hold queue's release marking surfaces differently. Bytes come out before the frame closes, a rolled-back byte reaches the sink, or the end-of-frame tag lands on the wrong byte. These are visible as soon as the closing flag or the abort has been processed, two cycles after its last bit. The bench therefore compares whole byte sequences with their tags rather than single bytes.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              eof;
    logic              abort;
    logic              rel;    // released: may leave toward the sink
  } hold_ent_t;
endpackage

// File: rtl/hdlc_bit_decoder.sv
module hdlc_bit_decoder
  import hdlc_rx_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output logic              close_evt,
  output logic              abort_evt
);
  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_RUN = STUFF_RUN + 2;
  localparam int RUN_W     = $clog2(ABORT_RUN + 1);
  localparam int CNT_W     = $clog2(BYTE_W);

  logic [RUN_W-1:0]  ones;
  logic              in_frame;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bcnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ones      <= '0;
      in_frame  <= 1'b0;
      shreg     <= '0;
      bcnt      <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      close_evt <= 1'b0;
      abort_evt <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      close_evt <= 1'b0;
      abort_evt <= 1'b0;
      if (bit_valid) begin
        if (bit_in) begin
          if (ones != RUN_W'(ABORT_RUN)) ones <= ones + 1'b1;
          if (in_frame) begin
            if (ones == RUN_W'(ABORT_RUN - 1)) begin
              abort_evt <= 1'b1;
              in_frame  <= 1'b0;
              shreg     <= '0;
              bcnt      <= '0;
            end else begin
              shreg <= {1'b1, shreg[BYTE_W-1:1]};
              if (bcnt == CNT_W'(BYTE_W - 1)) begin
                byte_vld  <= 1'b1;
                byte_data <= {1'b1, shreg[BYTE_W-1:1]};
                bcnt      <= '0;
              end else begin
                bcnt <= bcnt + 1'b1;
              end
            end
          end
        end else begin
          ones <= '0;
          if (ones == RUN_W'(FLAG_RUN)) begin
            close_evt <= in_frame;
            in_frame  <= 1'b1;
            shreg     <= '0;
            bcnt      <= '0;
          end else if (in_frame && ones != RUN_W'(STUFF_RUN)) begin
            shreg <= {1'b0, shreg[BYTE_W-1:1]};
            if (bcnt == CNT_W'(BYTE_W - 1)) begin
              byte_vld  <= 1'b1;
              byte_data <= {1'b0, shreg[BYTE_W-1:1]};
              bcnt      <= '0;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_hold_queue.sv
module hdlc_hold_queue
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int HOLD  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              close_evt,
  input  logic              abort_evt,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_eof,
  output logic              out_abort
);
  localparam int CW = $clog2(DEPTH + 1);

  hold_ent_t       q  [DEPTH];
  hold_ent_t       qn [DEPTH];
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   cn;
  logic            pop;
  logic            dropped;

  assign out_valid = (cnt != '0) && q[0].rel;
  assign out_data  = q[0].data;
  assign out_eof   = q[0].eof;
  assign out_abort = q[0].abort;
  assign pop       = out_valid && out_ready;

  always_comb begin
    qn      = q;
    cn      = cnt;
    dropped = 1'b0;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) qn[i] = q[i+1];
      qn[DEPTH-1] = '0;
      cn = cnt - 1'b1;
    end
    if (byte_vld) begin
      for (int i = 0; i < DEPTH; i++)
        if (i + HOLD == int'(cn)) qn[i].rel = 1'b1;
      if (int'(cn) != DEPTH) begin
        for (int i = 0; i < DEPTH; i++)
          if (i == int'(cn)) qn[i] = '{data: byte_data, eof: 1'b0, abort: 1'b0, rel: 1'b0};
        cn = cn + 1'b1;
      end
    end else if (close_evt) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i + 1 == int'(cn) && !qn[i].rel) qn[i].eof = 1'b1;
        if (i < int'(cn)) qn[i].rel = 1'b1;
      end
    end else if (abort_evt) begin
      for (int i = 0; i < DEPTH; i++)
        if (i + 1 == int'(cn) && !qn[i].rel) begin
          qn[i]   = '0;
          dropped = 1'b1;
        end
      if (dropped) cn = cn - 1'b1;
      for (int i = 0; i < DEPTH; i++)
        if (dropped && i + 1 == int'(cn) && !qn[i].rel) begin
          qn[i].rel   = 1'b1;
          qn[i].eof   = 1'b1;
          qn[i].abort = 1'b1;
        end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else begin
      cnt <= cn;
      for (int i = 0; i < DEPTH; i++) q[i] <= qn[i];
    end
  end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int STUFF_RUN = 5,
  parameter int Q_DEPTH   = 4,
  parameter int HOLD      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_eof,
  output logic              out_abort,
  output logic              abort_irq
);
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_data;
  logic              close_evt;
  logic              abort_evt;

  hdlc_bit_decoder #(.STUFF_RUN(STUFF_RUN)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .en        (rx_en),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .close_evt (close_evt),
    .abort_evt (abort_evt)
  );

  hdlc_hold_queue #(.DEPTH(Q_DEPTH), .HOLD(HOLD)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .en        (rx_en),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .close_evt (close_evt),
    .abort_evt (abort_evt),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_eof   (out_eof),
    .out_abort (out_abort)
  );

  assign abort_irq = abort_evt;
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_en,
  input logic       out_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_eof,
  input logic       out_abort,
  input logic       abort_irq
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!out_valid && !abort_irq));

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (rst) abort_irq |=> !abort_irq);

  // R8
  disable_clears_chk: assert property (@(posedge clk) disable iff (rst) !rx_en |=> !out_valid);

  // R9
  stall_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && rx_en) |=>
      (out_valid && $stable(out_data) && $stable(out_eof) && $stable(out_abort)));

  // R10
  abort_with_eof_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_abort) |-> out_eof);
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_en     (rx_en),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_eof   (out_eof),
  .out_abort (out_abort),
  .abort_irq (abort_irq)
);

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       out_ready = 1'b1;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_eof;
  logic       out_abort;
  logic       abort_irq;

  int errors = 0;
  int checks = 0;
  int gcount = 0;
  int irqcnt = 0;
  int tx_ones = 0;
  int gap = 0;
  bit done = 1'b0;
  logic [7:0] got_d [32];
  logic       got_e [32];
  logic       got_a [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_deframer u_dut (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_eof   (out_eof),
    .out_abort (out_abort),
    .abort_irq (abort_irq)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready) begin
        if (gcount < 32) begin
          got_d[gcount] = out_data;
          got_e[gcount] = out_eof;
          got_a[gcount] = out_abort;
        end
        gcount++;
      end
      if (abort_irq) irqcnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_entry(input int idx, input logic [7:0] d, input bit e, input bit a, input string req);
    if (idx >= gcount) begin
      check(1'b0, req, "missing byte", gcount, idx + 1);
    end else begin
      check(got_d[idx] == d, req, "data", got_d[idx], d);
      check(got_e[idx] == e && got_a[idx] == a, req, "eof/abort tags",
            {got_e[idx], got_a[idx]}, {e, a});
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #2;
      bit_valid = 1'b0;
    end
  endtask

  task automatic send_bit(input logic b);
    @(posedge clk); #2;
    bit_valid = 1'b1;
    bit_in    = b;
    if (gap != 0) idle(gap);
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    repeat (6) send_bit(1'b1);
    send_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      send_bit(b[i]);
      if (b[i]) tx_ones++; else tx_ones = 0;
      if (tx_ones == 5) begin
        send_bit(1'b0);
        tx_ones = 0;
      end
    end
  endtask

  task automatic send_raw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic send_abort();
    repeat (7) send_bit(1'b1);
    tx_ones = 0;
  endtask

  task automatic start_scenario();
    idle(2);
    gcount = 0;
    irqcnt = 0;
  endtask

  // R1: reset state
  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(abort_irq == 1'b0, "R1", "abort_irq in reset", abort_irq, 0);
  endtask

  // R2: bits before any flag are ignored
  task automatic t_hunt();
    start_scenario();
    send_raw(8'hA5);
    send_raw(8'h33);
    send_raw(8'hFF);
    send_raw(8'h00);
    idle(8);
    check(gcount == 0, "R2", "bytes before flag", gcount, 0);
    check(irqcnt == 0, "R2", "irq before flag", irqcnt, 0);
  endtask

  // R3, R4: stuffed frame closes with eof on last byte
  task automatic t_frame();
    start_scenario();
    send_flag();
    send_byte(8'hA5); send_byte(8'h7E); send_byte(8'hFF);
    send_byte(8'h1F); send_byte(8'hF8);
    send_flag();
    idle(8);
    check(gcount == 5, "R4", "frame byte count", gcount, 5);
    expect_entry(0, 8'hA5, 1'b0, 1'b0, "R3");
    expect_entry(1, 8'h7E, 1'b0, 1'b0, "R3");
    expect_entry(2, 8'hFF, 1'b0, 1'b0, "R3");
    expect_entry(3, 8'h1F, 1'b0, 1'b0, "R4");
    expect_entry(4, 8'hF8, 1'b1, 1'b0, "R4");
  endtask

  // R3: bit_valid gaps between bits
  task automatic t_gaps();
    start_scenario();
    gap = 2;
    send_flag();
    send_byte(8'h3E); send_byte(8'hC1);
    send_flag();
    gap = 0;
    idle(8);
    check(gcount == 2, "R3", "gapped frame count", gcount, 2);
    expect_entry(0, 8'h3E, 1'b0, 1'b0, "R3");
    expect_entry(1, 8'hC1, 1'b1, 1'b0, "R3");
  endtask

  // R5: back-to-back flags
  task automatic t_flags();
    start_scenario();
    repeat (4) send_flag();
    idle(8);
    check(gcount == 0, "R5", "bytes from flags only", gcount, 0);
  endtask

  // R6, R7, R10, R2: abort rolls back newest held byte
  task automatic t_abort();
    start_scenario();
    send_flag();
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h35);
    send_abort();
    send_raw(8'hFF);
    send_raw(8'h00);
    send_raw(8'h5A);
    idle(8);
    check(irqcnt == 1, "R7", "abort pulses", irqcnt, 1);
    check(gcount == 2, "R6", "bytes after abort", gcount, 2);
    expect_entry(0, 8'h11, 1'b0, 1'b0, "R6");
    expect_entry(1, 8'h22, 1'b1, 1'b1, "R6");
    send_flag();
    send_byte(8'h5A);
    send_flag();
    idle(8);
    check(gcount == 3, "R2", "frame after hunt", gcount, 3);
    expect_entry(2, 8'h5A, 1'b1, 1'b0, "R10");
  endtask

  // R6: abort with a single held byte delivers nothing
  task automatic t_abort_short();
    start_scenario();
    send_flag();
    send_byte(8'h44);
    send_abort();
    send_flag();
    send_flag();
    idle(8);
    check(gcount == 0, "R6", "bytes after short abort", gcount, 0);
    check(irqcnt == 1, "R7", "short abort pulses", irqcnt, 1);
  endtask

  // R8: disabling clears held bytes and re-enters hunt
  task automatic t_disable();
    start_scenario();
    send_flag();
    send_byte(8'h66); send_byte(8'h77);
    idle(2);
    rx_en = 1'b0;
    idle(3);
    check(out_valid == 1'b0, "R8", "out_valid while disabled", out_valid, 0);
    rx_en = 1'b1;
    send_byte(8'h88);
    send_flag();
    send_byte(8'h99);
    send_flag();
    idle(8);
    check(gcount == 1, "R8", "bytes after re-enable", gcount, 1);
    expect_entry(0, 8'h99, 1'b1, 1'b0, "R8");
  endtask

  // R9: backpressure keeps order
  task automatic t_backpressure();
    start_scenario();
    out_ready = 1'b0;
    send_flag();
    send_byte(8'hC3); send_byte(8'h3C); send_byte(8'h0F);
    send_flag();
    idle(6);
    check(gcount == 0, "R9", "bytes taken while stalled", gcount, 0);
    check(out_valid == 1'b1 && out_data == 8'hC3, "R9", "head byte while stalled",
          out_data, 8'hC3);
    out_ready = 1'b1;
    idle(8);
    check(gcount == 3, "R9", "bytes after stall", gcount, 3);
    expect_entry(0, 8'hC3, 1'b0, 1'b0, "R9");
    expect_entry(1, 8'h3C, 1'b0, 1'b0, "R9");
    expect_entry(2, 8'h0F, 1'b1, 1'b0, "R9");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    rx_en = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    @(posedge clk); #2;
    rst = 1'b0;
    t_hunt();
    t_frame();
    t_gaps();
    t_flags();
    t_abort();
    t_abort_short();
    t_disable();
    t_backpressure();
    finish_run();
  end
endmodule